// File: doc/BRIEF.md
# RTC Interrupt Status and Periodic Sampler

This block produces the interrupt flags of a real-time clock. A binary prescaler counts enable pulses from the 32768 Hz reference. Rising edges of its upper divided bits give a 1 Hz update event and nine sample events at 2, 4, 8, 16, 32, 64, 128, 256 and 512 Hz. Two further events, alarm match and stopwatch expiry, arrive as single-cycle pulses from the timekeeping logic outside the block.

Every event sets a sticky bit in a 16-bit status register. Software clears a bit by writing 1 to it through a simple register port. A 16-bit enable register masks the status bits onto one level-sensitive interrupt line. The status register sits at offset 0x14 and the enable register at offset 0x18. Reads are combinational from the read address.

Top module: `rtc_irq_sampler`

## Requirements
- R1: After reset the status register, the enable register and the prescaler count are all zero, and `irq` is low.
- R2: A pulse on `stopwatch_evt` sets status bit 0 and a pulse on `alarm_evt` sets status bit 2. Each bit stays set after the pulse ends.
- R3: The prescaler count advances on each cycle with `ref_tick` high. A periodic status bit is set in the cycle whose tick makes the matching count bit rise. Bit 4 (1 Hz) follows count bit 14, bit 7 (2 Hz) follows count bit 13, and bits 8 to 15 (4 Hz up to 512 Hz) follow count bits 12 down to 5. The first 512 Hz flag (bit 15) therefore appears on the 32nd tick after reset.
- R4: A write to the status offset clears every status bit written as 1 and leaves every bit written as 0. Writing 0xFFFF clears all flags.
- R5: If an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R6: A write to the enable offset replaces the enable register. `irq` is high exactly while at least one status bit and its enable bit are both 1.
- R7: Only bits 0, 2, 4, 7 and 8 to 15 exist in either register. The other bits read as 0 and ignore writes.
- R8: The status register is at offset 0x14 and the enable register at offset 0x18. Reads at any other offset return 0, and writes there change nothing.
- R9: While `ref_tick` is low the prescaler holds its count, and no periodic status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One pulse per period of the 32768 Hz reference |
| alarm_evt | input | 1 | Alarm match pulse |
| stopwatch_evt | input | 1 | Stopwatch expiry pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (8) | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_addr | input | ADDR_W (8) | Read byte offset |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Level interrupt: OR of status AND enable |

## Verification
The bench counts exactly 31 and then 32 ticks to find the first 512 Hz flag. A prescaler that tapped the wrong bit, or that set flags on a falling edge, would miss that cycle. It runs the count past 16384 ticks, so that the 4 Hz, 2 Hz and 1 Hz flags each fire at least once. It also stalls the tick to show that the count holds. A same-cycle alarm pulse and clear of bit 2 must leave the bit set; a design that let the clear win would drop the event. Writes of zero, writes of all ones, writes to stray offsets and writes to unassigned bits show up in the read data when the design mishandles them. A random phase interleaves all of these while `irq` is compared against the enabled flags every cycle.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

   localparam int REG_W         = 16;
   localparam int POS_STOPWATCH = 0;
   localparam int POS_ALARM     = 2;
   localparam int POS_SECOND    = 4;
   localparam int POS_HALF      = 7;
   localparam int SAMPLE_BASE   = 8;
   localparam int NUM_SAMPLE    = 8;
   // 1 Hz, 2 Hz and the eight sample rates: ten prescaler taps
   localparam int RATE_TAPS     = NUM_SAMPLE + 2;

   localparam logic [REG_W-1:0] IMPL_MASK =
      (16'hFFFF << SAMPLE_BASE)
      | (16'h1 << POS_HALF)
      | (16'h1 << POS_SECOND)
      | (16'h1 << POS_ALARM)
      | (16'h1 << POS_STOPWATCH);

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_ENABLE = 2'd2
   } reg_sel_e;

endpackage

// File: rtl/rtc_irq_prescaler.sv
module rtc_irq_prescaler #(
   parameter int PRESCALE_W = 15,
   parameter int NUM_OUT    = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_tick,
   output logic [NUM_OUT-1:0] rise
);

   logic [PRESCALE_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         count_q <= '0;
      else if (ref_tick)
         count_q <= count_q + 1'b1;
   end

   // rise[j] is the tap of count bit PRESCALE_W-NUM_OUT+j.
   // A bit rises when the bits below it are all ones, it is zero, and a tick arrives.
   for (genvar j = 0; j < NUM_OUT; j++) begin : g_tap
      localparam int K = PRESCALE_W - NUM_OUT + j;
      if (K == 0) begin : g_lsb
         assign rise[j] = ref_tick & ~count_q[0];
      end else begin : g_upper
         assign rise[j] = ref_tick & ~count_q[K] & (&count_q[K-1:0]);
      end
   end

endmodule

// File: rtl/rtc_irq_event_map.sv
module rtc_irq_event_map
   import rtc_irq_pkg::*;
(
   input  logic [RATE_TAPS-1:0] rise,
   input  logic                 alarm_evt,
   input  logic                 stopwatch_evt,
   output logic [REG_W-1:0]     set_vec
);

   // rise[RATE_TAPS-1] is 1 Hz, rise[RATE_TAPS-2] is 2 Hz, and rise[0] is the fastest rate
   logic [NUM_SAMPLE-1:0] sample_set;

   for (genvar i = 0; i < NUM_SAMPLE; i++) begin : g_sample
      assign sample_set[i] = rise[NUM_SAMPLE-1-i];
   end

   always_comb begin
      set_vec                                       = '0;
      set_vec[POS_STOPWATCH]                        = stopwatch_evt;
      set_vec[POS_ALARM]                            = alarm_evt;
      set_vec[POS_SECOND]                           = rise[RATE_TAPS-1];
      set_vec[POS_HALF]                             = rise[RATE_TAPS-2];
      set_vec[SAMPLE_BASE +: NUM_SAMPLE]            = sample_set;
   end

endmodule

// File: rtl/rtc_irq_decode.sv
module rtc_irq_decode
   import rtc_irq_pkg::*;
#(
   parameter int                ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] STATUS_OFS = 'h14,
   parameter logic [ADDR_W-1:0] ENABLE_OFS = 'h18
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              wr_status,
   output logic              wr_enable,
   output reg_sel_e          rd_sel
);

   assign wr_status = wr_en && (wr_addr == STATUS_OFS);
   assign wr_enable = wr_en && (wr_addr == ENABLE_OFS);

   always_comb begin
      if (rd_addr == STATUS_OFS)
         rd_sel = SEL_STATUS;
      else if (rd_addr == ENABLE_OFS)
         rd_sel = SEL_ENABLE;
      else
         rd_sel = SEL_NONE;
   end

endmodule

// File: rtl/rtc_irq_flag_bank.sv
module rtc_irq_flag_bank
   import rtc_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] set_vec,
   input  logic             wr_status,
   input  logic             wr_enable,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] status_q,
   output logic [REG_W-1:0] enable_q
);

   logic [REG_W-1:0] clr_vec;
   logic [REG_W-1:0] status_d;
   logic [REG_W-1:0] enable_d;

   assign clr_vec = wr_status ? wr_data : '0;

   // A set is applied after the clear, so an event wins over a clear in the same cycle
   always_comb begin
      status_d = ((status_q & ~clr_vec) | set_vec) & IMPL_MASK;
      enable_d = wr_enable ? (wr_data & IMPL_MASK) : enable_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         enable_q <= '0;
      end else begin
         status_q <= status_d;
         enable_q <= enable_d;
      end
   end

endmodule

// File: rtl/rtc_irq_sampler.sv
module rtc_irq_sampler
   import rtc_irq_pkg::*;
#(
   parameter int                ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] STATUS_OFS = 'h14,
   parameter logic [ADDR_W-1:0] ENABLE_OFS = 'h18,
   parameter int                PRESCALE_W = 15,
   parameter bit                IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              alarm_evt,
   input  logic              stopwatch_evt,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [15:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [15:0]       rd_data,
   output logic              irq
);

   if (PRESCALE_W < RATE_TAPS) begin : g_chk_width
      $error("PRESCALE_W must be at least RATE_TAPS");
   end
   if (STATUS_OFS == ENABLE_OFS) begin : g_chk_ofs
      $error("status and enable offsets must differ");
   end

   logic [RATE_TAPS-1:0] rise;
   logic [REG_W-1:0]     set_vec;
   logic [REG_W-1:0]     status_q;
   logic [REG_W-1:0]     enable_q;
   logic                 wr_status;
   logic                 wr_enable;
   reg_sel_e             rd_sel;

   rtc_irq_prescaler #(
      .PRESCALE_W (PRESCALE_W),
      .NUM_OUT    (RATE_TAPS)
   ) u_prescaler (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_tick (ref_tick),
      .rise     (rise)
   );

   rtc_irq_event_map u_event_map (
      .rise          (rise),
      .alarm_evt     (alarm_evt),
      .stopwatch_evt (stopwatch_evt),
      .set_vec       (set_vec)
   );

   rtc_irq_decode #(
      .ADDR_W     (ADDR_W),
      .STATUS_OFS (STATUS_OFS),
      .ENABLE_OFS (ENABLE_OFS)
   ) u_decode (
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .rd_addr   (rd_addr),
      .wr_status (wr_status),
      .wr_enable (wr_enable),
      .rd_sel    (rd_sel)
   );

   rtc_irq_flag_bank u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_vec   (set_vec),
      .wr_status (wr_status),
      .wr_enable (wr_enable),
      .wr_data   (wr_data),
      .status_q  (status_q),
      .enable_q  (enable_q)
   );

   always_comb begin
      unique case (rd_sel)
         SEL_STATUS: rd_data = status_q;
         SEL_ENABLE: rd_data = enable_q;
         default:    rd_data = '0;
      endcase
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            irq_q <= 1'b0;
         else
            irq_q <= |(status_q & enable_q);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(status_q & enable_q);
   end

endmodule

// File: rtl/rtc_irq_sampler_chk.sv
module rtc_irq_sampler_chk #(
   parameter int                ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] STATUS_OFS = 'h14,
   parameter logic [ADDR_W-1:0] ENABLE_OFS = 'h18,
   parameter bit                IRQ_REG    = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_tick,
   input logic              alarm_evt,
   input logic              stopwatch_evt,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [15:0]       wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [15:0]       rd_data,
   input logic              irq,
   input logic [15:0]       status_q,
   input logic [15:0]       enable_q
);

   logic st_wr;
   assign st_wr = wr_en && (wr_addr == STATUS_OFS);

   assert_stopwatch_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stopwatch_evt |=> status_q[0]);

   assert_alarm_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |=> status_q[2]);

   assert_fast_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[15]) |-> $past(ref_tick));

   assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && wr_data[0] && !stopwatch_evt) |=> !status_q[0]);

   assert_zero_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[2] && !(st_wr && wr_data[2])) |=> status_q[2]);

   assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_evt && st_wr && wr_data[2]) |=> status_q[2]);

   if (IRQ_REG) begin : g_irq_reg
      assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (status_q[2] && enable_q[2]) |=> irq);
      assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (enable_q == 16'h0) |=> !irq);
   end else begin : g_irq_comb
      assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (status_q[2] && enable_q[2]) |-> irq);
      assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (enable_q == 16'h0) |-> !irq);
   end

   assert_unassigned_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == STATUS_OFS || rd_addr == ENABLE_OFS) |-> ((rd_data & 16'h006A) == 16'h0));

   assert_other_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr != STATUS_OFS && rd_addr != ENABLE_OFS) |-> (rd_data == 16'h0));

   assert_tick_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_tick && !wr_en) |=> ($stable(status_q[15:7]) && $stable(status_q[4])));

endmodule

bind rtc_irq_sampler rtc_irq_sampler_chk #(
   .ADDR_W     (ADDR_W),
   .STATUS_OFS (STATUS_OFS),
   .ENABLE_OFS (ENABLE_OFS),
   .IRQ_REG    (IRQ_REG)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ref_tick      (ref_tick),
   .alarm_evt     (alarm_evt),
   .stopwatch_evt (stopwatch_evt),
   .wr_en         (wr_en),
   .wr_addr       (wr_addr),
   .wr_data       (wr_data),
   .rd_addr       (rd_addr),
   .rd_data       (rd_data),
   .irq           (irq),
   .status_q      (status_q),
   .enable_q      (enable_q)
);

// File: tb/rtc_irq_sampler_tb.sv
module rtc_irq_sampler_tb;

   localparam logic [7:0]  ST_OFS  = 8'h14;
   localparam logic [7:0]  EN_OFS  = 8'h18;
   localparam logic [15:0] MASK    = 16'hFF95;
   localparam time         CLK_PER = 4ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        alarm_evt = 1'b0;
   logic        stopwatch_evt = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        irq;

   int total = 0;
   int bad   = 0;

   logic [14:0] m_cnt = '0;
   logic [15:0] m_stat = '0;
   logic [15:0] m_en = '0;

   always #(CLK_PER/2) clk = ~clk;

   rtc_irq_sampler u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .ref_tick      (ref_tick),
      .alarm_evt     (alarm_evt),
      .stopwatch_evt (stopwatch_evt),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .rd_addr       (rd_addr),
      .rd_data       (rd_data),
      .irq           (irq)
   );

   function automatic logic [15:0] f_set(input logic [14:0] c, input logic t,
                                         input logic a, input logic s);
      logic [15:0] v;
      logic [14:0] nc;
      v  = '0;
      nc = t ? c + 15'd1 : c;
      v[0] = s;
      v[2] = a;
      v[4] = nc[14] & ~c[14];
      v[7] = nc[13] & ~c[13];
      for (int i = 0; i < 8; i++)
         v[8+i] = nc[12-i] & ~c[12-i];
      return v;
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                      input logic [15:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock: drive at the falling edge, update the model at the rising edge
   task automatic step(input logic t, input logic a, input logic s, input logic we,
                       input logic [7:0] wa, input logic [15:0] wd);
      logic [15:0] clr;
      ref_tick = t; alarm_evt = a; stopwatch_evt = s;
      wr_en = we; wr_addr = wa; wr_data = wd;
      @(posedge clk);
      clr    = (we && wa == ST_OFS) ? wd : 16'h0;
      m_stat = ((m_stat & ~clr) | f_set(m_cnt, t, a, s)) & MASK;
      if (we && wa == EN_OFS) m_en = wd & MASK;
      if (t) m_cnt = m_cnt + 15'd1;
      @(negedge clk);
      ref_tick = 1'b0; alarm_evt = 1'b0; stopwatch_evt = 1'b0; wr_en = 1'b0;
   endtask

   task automatic check_all(input string tag);
      rd_addr = ST_OFS; #1;
      chk(rd_data == m_stat, {tag, " status"}, rd_data, m_stat);
      rd_addr = EN_OFS; #1;
      chk(rd_data == m_en, {tag, " enable"}, rd_data, m_en);
      chk(irq == |(m_stat & m_en), {tag, " irq"}, {15'd0, irq}, {15'd0, |(m_stat & m_en)});
   endtask

   initial begin
      #(CLK_PER * 300000);
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: state after reset
      check_all("R1");

      // R2: events set sticky bits with the prescaler stalled
      step(0, 1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      check_all("R2 alarm");
      step(0, 0, 1, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      check_all("R2 stopwatch");
      chk(m_stat == 16'h0005, "R2 model", m_stat, 16'h0005);

      // R6/R7: enable write, unassigned bits dropped
      step(0, 0, 0, 1, EN_OFS, 16'hFFFF);
      rd_addr = EN_OFS; #1;
      chk(rd_data == 16'hFF95, "R7 enable mask", rd_data, 16'hFF95);
      check_all("R6 all enabled");
      step(0, 0, 0, 1, EN_OFS, 16'h0000);
      check_all("R6 masked");
      step(0, 0, 0, 1, EN_OFS, 16'h0004);
      check_all("R6 alarm enabled");

      // R4: write-one-to-clear
      step(0, 0, 0, 1, ST_OFS, 16'h0001);
      check_all("R4 clear bit0");
      step(0, 0, 0, 1, ST_OFS, 16'h0000);
      check_all("R4 zero write");
      step(0, 0, 0, 1, ST_OFS, 16'hFFFF);
      check_all("R4 clear all");

      // R5: a set and a clear in one cycle
      step(0, 1, 0, 1, ST_OFS, 16'h0004);
      rd_addr = ST_OFS; #1;
      chk(rd_data[2] == 1'b1, "R5 set wins", rd_data, 16'h0004);
      check_all("R5");

      // R8: stray offset
      step(0, 0, 0, 1, 8'h10, 16'hFFFF);
      check_all("R8 stray write");
      rd_addr = 8'h10; #1;
      chk(rd_data == 16'h0, "R8 stray read", rd_data, 16'h0);
      step(0, 0, 0, 1, ST_OFS, 16'hFFFF);

      // R3/R9: first 512 Hz flag on the 32nd tick; stalls in between
      for (int i = 0; i < 31; i++) begin
         step(1, 0, 0, 0, 0, 0);
         if (i == 10) begin
            step(0, 0, 0, 0, 0, 0);
            step(0, 0, 0, 0, 0, 0);
         end
      end
      rd_addr = ST_OFS; #1;
      chk(rd_data[15] == 1'b0, "R3 before 32nd tick", rd_data, 16'h0);
      chk(rd_data == m_stat, "R9 stall", rd_data, m_stat);
      step(1, 0, 0, 0, 0, 0);
      rd_addr = ST_OFS; #1;
      chk(rd_data[15] == 1'b1, "R3 on 32nd tick", rd_data, 16'h8000);
      step(0, 0, 0, 1, EN_OFS, 16'hFF80);

      // R3: run past 16384 ticks so every rate fires
      for (int i = 0; i < 16500; i++) begin
         step(1, 0, 0, (i % 700) == 699, ST_OFS, 16'hFFFF);
         check_all("R3 run");
      end
      chk(m_cnt > 15'd16384, "R3 1 Hz reached", {1'b0, m_cnt}, 16'd16384);

      // random phase across R2..R9
      for (int i = 0; i < 20000; i++) begin
         logic [1:0]  pick;
         logic [7:0]  wa;
         pick = 2'($urandom % 4);
         wa   = (pick == 0) ? ST_OFS : (pick == 1) ? EN_OFS :
                (pick == 2) ? 8'h10 : 8'($urandom);
         step(($urandom % 10) != 0, ($urandom % 40) == 0, ($urandom % 40) == 0,
              ($urandom % 6) == 0, wa, 16'($urandom));
         check_all("R4 R5 R6 random");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule